// File: doc/BRIEF.md
# Strided Vector Move and Swap Engine

This block copies one strided vector of words onto another, or exchanges the two vectors element by element, in a 16-bit word-addressed memory with a 15-bit address space. A single start pulse loads two base addresses, two signed element strides, a signed element count, a swap-enable bit and a precision bit. The engine then runs the whole transfer on its own through one synchronous memory port and pulses done when it has finished.

An element is 2 words in single precision and 4 words in double precision. The words are opaque: nothing is computed on them. Every element pass fetches the full element of the first vector and then the full element of the second vector before it writes anything. The first vector's value goes to the second vector's location. In swap mode the second vector's old value then goes back to the first vector's location. Move and swap run the same sequence; swap only adds the final write group. When the vectors overlap, the result is whatever this fixed per-element order gives. No conflict detection is done.

The memory port issues at most one access per cycle. Read data is returned one cycle after the read request, which matches a registered memory.

Top module: `vec_move_swap`

## Requirements
- R1: A start with a count of zero or a negative count (two's complement) makes no memory access, and done is high in the cycle after the start edge.
- R2: The word step of each vector equals its signed stride times 2 in single mode (prec_dbl_i = 0) or times 4 in double mode (prec_dbl_i = 1). Negative strides move downward.
- R3: For each element the port first reads the words of vector 1 at ascending addresses, then reads the words of vector 2 at ascending addresses, then writes the vector 1 words to the vector 2 addresses at ascending addresses.
- R4: With swap_i = 1 the engine then writes the vector 2 words read earlier to the vector 1 addresses at ascending addresses. With swap_i = 0 that group is skipped. One transfer therefore makes exactly words*count*(4 or 3) accesses.
- R5: All addresses, both the element bases and the word offsets, wrap modulo 2^15.
- R6: Accesses take one cycle each with no gaps. done_o is a one-cycle pulse in the cycle after the last access, and busy_o is high from the start edge until done_o has fallen.
- R7: A start pulse while busy_o is high is ignored. The running transfer continues unchanged and no second transfer follows.
- R8: Read data on mem_rdata_i is taken in the cycle after the read request (latency one). A write uses mem_req_o = 1 with mem_we_o = 1.
- R9: After reset the engine is idle: busy_o, done_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a transfer |
| base1_i | input | 15 | Word address of the first element of vector 1 |
| base2_i | input | 15 | Word address of the first element of vector 2 |
| stride1_i | input | 16 | Signed element stride of vector 1 |
| stride2_i | input | 16 | Signed element stride of vector 2 |
| count_i | input | 16 | Signed number of elements |
| swap_i | input | 1 | 1 = exchange the vectors, 0 = copy vector 1 onto vector 2 |
| prec_dbl_i | input | 1 | 1 = 4-word elements, 0 = 2-word elements |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 15 | Word address of the access |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after a read request |

## Verification
Random transfers mix both precisions, both modes, strides from -3 to 3 and counts from -2 to 6. Some base pairs are placed a few words apart, so that overlap shows whether the fixed read-before-write order is kept. Directed cases then separate particular faults:
- Zero and negative counts catch an engine that accesses memory when it should not.
- A negative stride in double mode catches a wrong scale factor or a lost sign extension.
- A vector that straddles address 0x7FFF catches a wrong wrap.
- Move and swap on the same operands show whether the extra write group is present or missing.
- A start pulse while busy shows whether the running transfer is disturbed.

The full access trace, the final memory contents and the done timing are each compared against a bench model.

// File: rtl/vms_pkg.sv
package vms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_RD2  = 3'd2,
    ST_WR2  = 3'd3,
    ST_WR1  = 3'd4,
    ST_FIN  = 3'd5
  } vms_state_e;

endpackage

// File: rtl/vms_addr_gen.sv
module vms_addr_gen #(
  parameter int AW = 15,
  parameter int SW = 16,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 adv_i,
  input  logic                 dbl_i,
  input  logic [1:0][AW-1:0]   base_i,
  input  logic [1:0][SW-1:0]   stride_i,
  input  logic                 vsel_i,
  input  logic [IW-1:0]        widx_i,
  output logic [AW-1:0]        addr_o
);

  localparam int XW = (SW + 2 > AW) ? SW + 2 : AW;

  logic [1:0][AW-1:0] ptr_q;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic signed [XW-1:0] step_x2;
    logic signed [XW-1:0] step_x4;
    logic [AW-1:0]        step_d;
    logic [AW-1:0]        step_q;
    logic [AW-1:0]        ptr_d;
    logic                 ptr_en;

    always_comb begin
      step_x2 = XW'($signed({stride_i[g], 1'b0}));
      step_x4 = XW'($signed({stride_i[g], 2'b00}));
      step_d  = dbl_i ? step_x4[AW-1:0] : step_x2[AW-1:0];
    end

    always_comb begin
      ptr_en = load_i | adv_i;
      ptr_d  = load_i ? base_i[g] : ptr_q[g] + step_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
        step_q   <= '0;
      end else begin
        if (ptr_en) ptr_q[g] <= ptr_d;
        if (load_i) step_q   <= step_d;
      end
    end
  end

  assign addr_o = ptr_q[vsel_i] + AW'(widx_i);

endmodule

// File: rtl/vms_elem_buf.sv
module vms_elem_buf #(
  parameter int DW    = 16,
  parameter int WORDS = 4,
  parameter int IW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_i,
  input  logic           rsel_i,
  input  logic [IW-1:0]  ridx_i,
  input  logic [DW-1:0]  rdata_i,
  input  logic           osel_i,
  input  logic [IW-1:0]  oidx_i,
  output logic [DW-1:0]  data_o
);

  localparam int SLOTS = 2 * WORDS;

  logic          pend_q;
  logic          psel_q;
  logic [IW-1:0] pidx_q;
  logic [DW-1:0] slot [SLOTS];

  // Remember which slot the outstanding read belongs to
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      psel_q <= 1'b0;
      pidx_q <= '0;
    end else begin
      pend_q <= rd_i;
      if (rd_i) begin
        psel_q <= rsel_i;
        pidx_q <= ridx_i;
      end
    end
  end

  for (genvar v = 0; v < 2; v++) begin : g_vec
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic          cap_en;
      logic [DW-1:0] word_q;

      assign cap_en = pend_q && (psel_q == v[0]) && (pidx_q == IW'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (cap_en) word_q <= rdata_i;
      end

      assign slot[v*WORDS + w] = word_q;
    end
  end

  assign data_o = slot[int'({osel_i, oidx_i})];

endmodule

// File: rtl/vms_ctrl.sv
module vms_ctrl
  import vms_pkg::*;
#(
  parameter int CW        = 16,
  parameter int IW        = 2,
  parameter int SGL_WORDS = 2,
  parameter int DBL_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          swap_i,
  input  logic          dbl_i,
  output logic          load_o,
  output logic          adv_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          req_o,
  output logic          we_o,
  output logic          rd_o,
  output logic          vsel_o,
  output logic          dsel_o,
  output logic          dbl_o,
  output logic [IW-1:0] widx_o
);

  localparam logic [IW-1:0] LAST_SGL = IW'(SGL_WORDS - 1);
  localparam logic [IW-1:0] LAST_DBL = IW'(DBL_WORDS - 1);

  vms_state_e    state_q, state_d;
  logic [IW-1:0] widx_q, widx_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          swap_q, dbl_q;
  logic          last_w;
  logic          elem_end;
  logic          step_en;

  assign last_w = (widx_q == (dbl_q ? LAST_DBL : LAST_SGL));
  assign load_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d  = state_q;
    widx_d   = widx_q;
    rem_d    = rem_q;
    elem_end = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        widx_d = '0;
        if (start_i) begin
          if ($signed(count_i) <= 0) begin
            state_d = ST_FIN;
          end else begin
            state_d = ST_RD1;
            rem_d   = count_i;
          end
        end
      end
      ST_RD1: begin
        widx_d = last_w ? '0 : widx_q + 1'b1;
        if (last_w) state_d = ST_RD2;
      end
      ST_RD2: begin
        widx_d = last_w ? '0 : widx_q + 1'b1;
        if (last_w) state_d = ST_WR2;
      end
      ST_WR2: begin
        widx_d = last_w ? '0 : widx_q + 1'b1;
        if (last_w) begin
          if (swap_q) state_d = ST_WR1;
          else        elem_end = 1'b1;
        end
      end
      ST_WR1: begin
        widx_d = last_w ? '0 : widx_q + 1'b1;
        if (last_w) elem_end = 1'b1;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (elem_end) begin
      rem_d   = rem_q - 1'b1;
      state_d = (rem_q == CW'(1)) ? ST_FIN : ST_RD1;
    end
  end

  assign step_en = (state_q != ST_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      rem_q   <= '0;
      swap_q  <= 1'b0;
      dbl_q   <= 1'b0;
    end else begin
      if (step_en) begin
        state_q <= state_d;
        widx_q  <= widx_d;
        rem_q   <= rem_d;
      end
      if (load_o) begin
        swap_q <= swap_i;
        dbl_q  <= dbl_i;
      end
    end
  end

  always_comb begin
    adv_o  = elem_end;
    busy_o = (state_q != ST_IDLE);
    done_o = (state_q == ST_FIN);
    rd_o   = (state_q == ST_RD1) || (state_q == ST_RD2);
    we_o   = (state_q == ST_WR1) || (state_q == ST_WR2);
    req_o  = rd_o || we_o;
    vsel_o = (state_q == ST_RD2) || (state_q == ST_WR2);
    dsel_o = (state_q == ST_WR1);
    dbl_o  = dbl_q;
    widx_o = widx_q;
  end

endmodule

// File: rtl/vec_move_swap.sv
module vec_move_swap #(
  parameter int AW        = 15,
  parameter int DW        = 16,
  parameter int SW        = 16,
  parameter int CW        = 16,
  parameter int SGL_WORDS = 2,
  parameter int DBL_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base1_i,
  input  logic [AW-1:0] base2_i,
  input  logic [SW-1:0] stride1_i,
  input  logic [SW-1:0] stride2_i,
  input  logic [CW-1:0] count_i,
  input  logic          swap_i,
  input  logic          prec_dbl_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);

  localparam int IW = (DBL_WORDS > 1) ? $clog2(DBL_WORDS) : 1;

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic          load, adv, rd, vsel, dsel, dbl_q;
  logic [IW-1:0] widx;

  vms_ctrl #(
    .CW(CW), .IW(IW), .SGL_WORDS(SGL_WORDS), .DBL_WORDS(DBL_WORDS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .count_i (count_i),
    .swap_i  (swap_i),
    .dbl_i   (prec_dbl_i),
    .load_o  (load),
    .adv_o   (adv),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .rd_o    (rd),
    .vsel_o  (vsel),
    .dsel_o  (dsel),
    .dbl_o   (dbl_q),
    .widx_o  (widx)
  );

  vms_addr_gen #(
    .AW(AW), .SW(SW), .IW(IW)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load),
    .adv_i    (adv),
    .dbl_i    (prec_dbl_i),
    .base_i   ({base2_i, base1_i}),
    .stride_i ({stride2_i, stride1_i}),
    .vsel_i   (vsel),
    .widx_i   (widx),
    .addr_o   (mem_addr_o)
  );

  vms_elem_buf #(
    .DW(DW), .WORDS(DBL_WORDS), .IW(IW)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_i    (rd),
    .rsel_i  (vsel),
    .ridx_i  (widx),
    .rdata_i (mem_rdata_i),
    .osel_i  (dsel),
    .oidx_i  (widx),
    .data_o  (mem_wdata_o)
  );

  logic unused_dbl;
  assign unused_dbl = dbl_q;

endmodule

// File: rtl/vec_move_swap_chk.sv
module vec_move_swap_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          start_i,
  input logic [CW-1:0] count_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o
);

  // R1: an empty or negative transfer only produces done
  a_r1_empty_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !busy_o && ($signed(count_i) <= 0)) |=> (done_o && !mem_req_o));

  // R6: done lasts exactly one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R7: once busy, the engine stays busy until it signals done
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && !done_o) |=> busy_o);

  // R9: no memory traffic while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy_o |-> !mem_req_o);

  // R8: a write is always a request
  a_r8_write_is_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we_o |-> mem_req_o);

endmodule

bind vec_move_swap vec_move_swap_chk #(.CW(CW)) u_chk (.*);

// File: tb/vec_move_swap_tb_top.sv
module vec_move_swap_tb_top;

  localparam int AW   = 15;
  localparam int DW   = 16;
  localparam int MASK = 32767;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] base1_i, base2_i;
  logic [15:0]   stride1_i, stride2_i, count_i;
  logic          swap_i, prec_dbl_i;
  logic          busy_o, done_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i;

  always #4 clk = ~clk;  // 125 MHz

  vec_move_swap dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .base1_i(base1_i), .base2_i(base2_i),
    .stride1_i(stride1_i), .stride2_i(stride2_i),
    .count_i(count_i), .swap_i(swap_i), .prec_dbl_i(prec_dbl_i),
    .busy_o(busy_o), .done_o(done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  int errors = 0;
  int checks = 0;
  int wd     = 0;

  logic [15:0] mem  [int];
  logic [15:0] rmem [int];
  logic [31:0] act_q [$];
  logic [31:0] exp_q [$];

  function automatic logic [15:0] init_word(int a);
    return 16'((a * 40503) ^ 23130);
  endfunction

  function automatic logic [15:0] mrd(int a);
    return mem.exists(a) ? mem[a] : init_word(a);
  endfunction

  function automatic logic [15:0] rrd(int a);
    return rmem.exists(a) ? rmem[a] : init_word(a);
  endfunction

  // Memory model, read latency one (R8), plus trace recorder
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        mem[int'(mem_addr_o)] = mem_wdata_o;
        act_q.push_back({1'b1, mem_addr_o, mem_wdata_o});
      end else begin
        mem_rdata_i <= mrd(int'(mem_addr_o));
        act_q.push_back({1'b0, mem_addr_o, 16'h0000});
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Bench model of one transfer (R2 R3 R4 R5)
  task automatic ref_run(input int b1, input int b2, input int s1, input int s2,
                         input int n, input bit swp, input bit dbl);
    int e;
    int a1;
    int a2;
    logic [15:0] t1 [4];
    logic [15:0] t2 [4];
    e  = dbl ? 4 : 2;
    a1 = b1;
    a2 = b2;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < e; k++) begin
        t1[k] = rrd((a1 + k) & MASK);
        exp_q.push_back({1'b0, 15'((a1 + k) & MASK), 16'h0000});
      end
      for (int k = 0; k < e; k++) begin
        t2[k] = rrd((a2 + k) & MASK);
        exp_q.push_back({1'b0, 15'((a2 + k) & MASK), 16'h0000});
      end
      for (int k = 0; k < e; k++) begin
        rmem[(a2 + k) & MASK] = t1[k];
        exp_q.push_back({1'b1, 15'((a2 + k) & MASK), t1[k]});
      end
      if (swp) begin
        for (int k = 0; k < e; k++) begin
          rmem[(a1 + k) & MASK] = t2[k];
          exp_q.push_back({1'b1, 15'((a1 + k) & MASK), t2[k]});
        end
      end
      a1 = (a1 + s1 * e) & MASK;
      a2 = (a2 + s2 * e) & MASK;
    end
  endtask

  task automatic do_op(input int b1, input int b2, input int s1, input int s2,
                       input int n, input bit swp, input bit dbl,
                       input bit poke, input string tag);
    int lat;
    int want;
    int bad;
    act_q.delete();
    exp_q.delete();
    ref_run(b1, b2, s1, s2, n, swp, dbl);
    want = exp_q.size() + 1;
    @(negedge clk);
    start_i    = 1'b1;
    base1_i    = 15'(b1);
    base2_i    = 15'(b2);
    stride1_i  = 16'(s1);
    stride2_i  = 16'(s2);
    count_i    = 16'(n);
    swap_i     = swp;
    prec_dbl_i = dbl;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 2000) begin
      if (poke && lat == 2) begin
        // R7: foreign request in the middle of a transfer
        start_i = 1'b1; base1_i = 15'd5; base2_i = 15'd9;
        count_i = 16'd3; swap_i = ~swp; prec_dbl_i = ~dbl;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    check(lat == want, {tag, " R6 done latency"}, lat, want);
    @(negedge clk);
    check(!done_o, {tag, " R6 done one cycle"}, int'(done_o), 0);
    repeat (4) @(negedge clk);
    check(!busy_o, {tag, " R7 idle after done"}, int'(busy_o), 0);
    // R3 / R4 / R5: trace of accesses, order and addresses
    bad = -1;
    if (act_q.size() == exp_q.size()) begin
      for (int i = 0; i < exp_q.size(); i++)
        if (bad < 0 && act_q[i] != exp_q[i]) bad = i;
      if (bad >= 0)
        check(1'b0, {tag, " R3 trace entry"}, int'(act_q[bad]), int'(exp_q[bad]));
      else
        check(1'b1, {tag, " R3 trace"}, 0, 0);
    end else begin
      check(1'b0, {tag, " R4 access count"}, act_q.size(), exp_q.size());
    end
    // R4 / R8: final memory image
    bad = -1;
    foreach (rmem[a]) if (bad < 0 && mrd(a) != rmem[a]) bad = a;
    foreach (mem[a])  if (bad < 0 && rrd(a) != mem[a])  bad = a;
    if (bad >= 0)
      check(1'b0, {tag, " R4/R8 memory word"}, int'(mrd(bad)), int'(rrd(bad)));
    else
      check(1'b1, {tag, " R4/R8 memory"}, 0, 0);
  endtask

  initial begin
    int b1, b2, s1, s2, n;
    bit swp, dbl;
    void'($urandom(32'd2718));
    rst_n = 1'b0; start_i = 1'b0; base1_i = '0; base2_i = '0;
    stride1_i = '0; stride2_i = '0; count_i = '0; swap_i = 1'b0; prec_dbl_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o, "R9 reset idle",
          int'({busy_o, done_o, mem_req_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o, "R9 idle after release",
          int'({busy_o, done_o, mem_req_o}), 0);

    // Directed corner cases
    do_op(100, 200, 1, 1, 0, 1'b1, 1'b0, 1'b0, "R1 zero count");
    do_op(100, 200, 1, 1, -5, 1'b0, 1'b1, 1'b0, "R1 negative count");
    do_op(300, 400, 1, 2, 4, 1'b0, 1'b0, 1'b0, "R3 move single");
    do_op(300, 400, 1, 2, 4, 1'b1, 1'b0, 1'b0, "R4 swap single");
    do_op(600, 700, -1, 3, 3, 1'b1, 1'b1, 1'b0, "R2 negative stride double");
    do_op(32766, 32760, 1, -2, 3, 1'b1, 1'b1, 1'b0, "R5 wrap double");
    do_op(1000, 1002, 1, 1, 5, 1'b0, 1'b0, 1'b0, "R3 overlap move");
    do_op(1200, 1300, 1, 1, 4, 1'b1, 1'b1, 1'b1, "R7 start while busy");

    // Constrained random transfers
    for (int t = 0; t < 50; t++) begin
      b1  = int'($urandom_range(MASK));
      b2  = ($urandom_range(1) == 0) ? int'($urandom_range(MASK))
                                     : (b1 + int'($urandom_range(8))) & MASK;
      s1  = int'($urandom_range(6)) - 3;
      s2  = int'($urandom_range(6)) - 3;
      n   = int'($urandom_range(8)) - 2;
      swp = 1'($urandom_range(1));
      dbl = 1'($urandom_range(1));
      do_op(b1, b2, s1, s2, n, swp, dbl, 1'($urandom_range(3) == 0), "R2 R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule